// File: doc/BRIEF.md
# Advanced Load Address Table

This block tracks loads that a compiler has moved above stores which might write the same memory. When such a hoisted load executes, it is registered in a small fully associative table under its destination register, together with the doubleword it read and a flag telling whether the load deferred an exception. Every later store is compared with all live entries. Any entry whose doubleword the store touches is marked as conflicted.

At the point where the original load stood, the program issues a check for the destination register. The plain check form, the check-load, answers "refetch" when the entry is conflicted or absent, and the reissued load then counts as good data. The branching form, the check-advanced, answers "fixup" in the same situations, because the stale value may already have been consumed. Either form reports the deferred exception of an entry that is present. A flush input empties the table. The memory system and the recovery code sit outside this block.

Top module: `adv_load_table`

## Requirements
- R1: An insert (`ins_valid`) records an entry for `ins_reg` holding the doubleword address `ins_addr[ADDR_W-1:3]`. A check on that register with no intervening conflict answers neither refetch nor fixup.
- R2: A register owns at most one entry. Inserting a register that is already present replaces its entry, including the address, conflict and deferred state.
- R3: The table holds `ENTRIES` (8) registers. Inserting a new register into a full table evicts the entry that was inserted least recently, and a later check of the evicted register sees a miss.
- R4: A store (`st_valid`) marks as conflicted every valid entry whose doubleword equals `st_addr[ADDR_W-1:3]`. Address bits [2:0] are ignored, and stores to other doublewords leave entries untouched.
- R5: A check-load (`chk_valid`, `chk_advanced`=0) on a missing or conflicted register raises `rsp_refetch` in the cycle after the check. A check-load that hits a conflicted entry clears the conflict and leaves the entry valid.
- R6: A check-advanced (`chk_advanced`=1) on a missing or conflicted register raises `rsp_fixup` in the cycle after the check, and it changes no table state.
- R7: Either check form that hits an entry inserted with `ins_defer`=1 raises `rsp_exc` with its response. A miss never raises `rsp_exc`.
- R8: When an insert and a store to the same doubleword occur in the same cycle, the new entry starts out conflicted.
- R9: `flush` invalidates every entry and overrides an insert in the same cycle.
- R10: A check answers from the table as it was before the cycle's updates. When a store conflict and a check-load clear hit the same entry in one cycle, the entry stays conflicted.
- R11: After reset the table is empty and all response outputs are 0. `rsp_valid` pulses for exactly one cycle after each check, and the response bits are 0 whenever `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| ins_valid | input | 1 | Advanced-load insert strobe |
| ins_reg | input | REG_W | Destination register of the advanced load |
| ins_addr | input | ADDR_W | Byte address read by the advanced load |
| ins_defer | input | 1 | The advanced load deferred an exception |
| st_valid | input | 1 | Store snoop strobe |
| st_addr | input | ADDR_W | Byte address written by the store |
| chk_valid | input | 1 | Check request strobe |
| chk_advanced | input | 1 | 0 = check-load, 1 = check-advanced |
| chk_reg | input | REG_W | Register being checked |
| rsp_valid | output | 1 | Check response present (one cycle after request) |
| rsp_refetch | output | 1 | Reissue the load |
| rsp_fixup | output | 1 | Branch to recovery code |
| rsp_exc | output | 1 | Raise the deferred exception |

## Verification
A corrupted entry in this table stays invisible until that register is checked. At that point it appears one cycle later as a wrong refetch, fixup or exception bit. A lost conflict bit lets stale data pass silently, and a stuck one causes spurious refetches. A wrong age order shows up only when a ninth register pushes out the wrong victim. The bench therefore follows every targeted scenario and a long stretch of mixed traffic with checks. It compares the four response bits against a behavioural model on every clock.

// File: rtl/adv_load_table.sv
module adv_load_table #(
  parameter int ENTRIES = 8,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              ins_valid,
  input  logic [REG_W-1:0]  ins_reg,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              ins_defer,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic              chk_advanced,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              rsp_valid,
  output logic              rsp_refetch,
  output logic              rsp_fixup,
  output logic              rsp_exc
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int DW_W  = ADDR_W - 3;
  localparam logic [ENTRIES-1:0] ONE = {{(ENTRIES-1){1'b0}}, 1'b1};
  localparam logic [IDX_W-1:0]   OLDEST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld, conf, dfr;
  logic [REG_W-1:0]   tag [ENTRIES];
  logic [DW_W-1:0]    dw  [ENTRIES];
  logic [IDX_W-1:0]   age [ENTRIES];

  wire [DW_W-1:0] ins_dw = ins_addr[ADDR_W-1:3];
  wire [DW_W-1:0] st_dw  = st_addr[ADDR_W-1:3];

  logic [ENTRIES-1:0] ins_hit, chk_hit, st_hit, old_slot, victim, alloc;
  logic [IDX_W-1:0]   vic_age;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign ins_hit[i]  = vld[i] && tag[i] == ins_reg;
    assign chk_hit[i]  = vld[i] && tag[i] == chk_reg;
    assign st_hit[i]   = vld[i] && dw[i] == st_dw;
    assign old_slot[i] = age[i] == OLDEST;
  end

  wire [ENTRIES-1:0] free       = ~vld;
  wire [ENTRIES-1:0] first_free = free & (~free + ONE);

  assign victim = (|ins_hit) ? ins_hit : (|free) ? first_free : old_slot;
  assign alloc  = (ins_valid && !flush) ? victim : '0;

  always_comb begin
    vic_age = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (victim[i]) vic_age = age[i];
  end

  wire chk_any = |chk_hit;
  wire chk_bad = !chk_any || |(chk_hit & conf);
  wire chk_dfr = |(chk_hit & dfr);
  wire new_conf = st_valid && st_dw == ins_dw;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[i]  <= 1'b0;
        conf[i] <= 1'b0;
        dfr[i]  <= 1'b0;
        tag[i]  <= '0;
        dw[i]   <= '0;
        age[i]  <= IDX_W'(i);
      end else if (flush) begin
        vld[i]  <= 1'b0;
      end else begin
        if (alloc[i]) begin
          vld[i]  <= 1'b1;
          tag[i]  <= ins_reg;
          dw[i]   <= ins_dw;
          dfr[i]  <= ins_defer;
          conf[i] <= new_conf;
        end else if (st_valid && st_hit[i]) begin
          conf[i] <= 1'b1;
        end else if (chk_valid && !chk_advanced && chk_hit[i]) begin
          conf[i] <= 1'b0;
        end
        if (ins_valid) begin
          if (alloc[i])               age[i] <= '0;
          else if (age[i] < vic_age)  age[i] <= age[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_refetch <= 1'b0;
      rsp_fixup   <= 1'b0;
      rsp_exc     <= 1'b0;
    end else begin
      rsp_valid   <= chk_valid;
      rsp_refetch <= chk_valid && !chk_advanced && chk_bad;
      rsp_fixup   <= chk_valid && chk_advanced && chk_bad;
      rsp_exc     <= chk_valid && chk_any && chk_dfr;
    end
  end

  logic [REG_W-1:0] prev_ins_reg;
  logic [DW_W-1:0]  prev_st_dw;
  logic [ENTRIES-1:0] prev_ins_seen, prev_st_match;

  always_ff @(posedge clk) begin
    prev_ins_reg <= ins_reg;
    prev_st_dw   <= st_dw;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
    assign prev_ins_seen[i] = vld[i] && tag[i] == prev_ins_reg;
    assign prev_st_match[i] = vld[i] && dw[i] == prev_st_dw;
  end

  assert_insert_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !flush |=> |prev_ins_seen);

  always_comb begin
    if (rst_n)
      for (int i = 0; i < ENTRIES; i++)
        for (int j = i + 1; j < ENTRIES; j++)
          assert_single_owner_R2: assert (!(vld[i] && vld[j] && tag[i] == tag[j]));
  end

  assert_store_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !flush |=> (prev_st_match & ~conf) == '0);

  assert_miss_refetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && !chk_advanced && !chk_any |=> rsp_refetch);

  assert_check_adv_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_advanced && !flush && !ins_valid && !st_valid |=> $stable(conf) && $stable(vld));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> vld == '0);

  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_refetch && !rsp_fixup && !rsp_exc);

endmodule

// File: tb/adv_load_table_test.sv
`timescale 1ns/1ps
module adv_load_table_test;
  logic clk = 0, rst_n = 0;
  logic flush = 0, ins_valid = 0, ins_defer = 0, st_valid = 0, chk_valid = 0, chk_advanced = 0;
  logic [6:0]  ins_reg = 0, chk_reg = 0;
  logic [31:0] ins_addr = 0, st_addr = 0;
  logic rsp_valid, rsp_refetch, rsp_fixup, rsp_exc;

  adv_load_table uut (.*);

  always #2 clk = ~clk;

  typedef struct { int r; logic [28:0] d; bit c; bit x; } ent_t;
  ent_t q[$];
  int vectors = 0, bad = 0;
  bit done = 0;

  function automatic int find(int r);
    foreach (q[j]) if (q[j].r == r) return j;
    return -1;
  endfunction

  task automatic step(string tg, bit fl, bit iv, int ir, logic [31:0] ia, bit idf,
                      bit sv, logic [31:0] sa, bit cv, bit ca, int cr);
    int k, k2;
    bit hit, miss_or_c, ev, er, ef, ex;
    @(negedge clk);
    flush = fl; ins_valid = iv; ins_reg = 7'(ir); ins_addr = ia; ins_defer = idf;
    st_valid = sv; st_addr = sa; chk_valid = cv; chk_advanced = ca; chk_reg = 7'(cr);
    k = find(cr); hit = k >= 0;
    miss_or_c = !hit || (hit && q[k].c);
    ev = cv; er = cv && !ca && miss_or_c; ef = cv && ca && miss_or_c;
    ex = cv && hit && q[k].x;
    if (fl) q.delete();
    else begin
      if (cv && !ca && hit) q[k].c = 0;
      if (sv) foreach (q[j]) if (q[j].d == sa[31:3]) q[j].c = 1;
      if (iv) begin
        k2 = find(ir);
        if (k2 >= 0) q.delete(k2);
        else if (q.size() == 8) void'(q.pop_front());
        q.push_back('{ir, ia[31:3], sv && sa[31:3] == ia[31:3], idf});
      end
    end
    @(posedge clk); #1;
    vectors++;
    if ({rsp_valid, rsp_refetch, rsp_fixup, rsp_exc} !== {ev, er, ef, ex}) begin
      bad++;
      $display("FAIL %s: v/refetch/fixup/exc actual %b%b%b%b expected %b%b%b%b",
               tg, rsp_valid, rsp_refetch, rsp_fixup, rsp_exc, ev, er, ef, ex);
    end
  endtask

  task automatic ins(string t, int r, logic [31:0] a, bit d = 0);
    step(t, 0, 1, r, a, d, 0, 0, 0, 0, 0);
  endtask
  task automatic st(string t, logic [31:0] a);
    step(t, 0, 0, 0, 0, 0, 1, a, 0, 0, 0);
  endtask
  task automatic ck(string t, bit adv, int r);
    step(t, 0, 0, 0, 0, 0, 0, 0, 1, adv, r);
  endtask
  task automatic idle(string t);
    step(t, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    if ({rsp_valid, rsp_refetch, rsp_fixup, rsp_exc} !== 4'b0) begin
      bad++; $display("FAIL R11: reset outputs actual %b expected 0000",
                      {rsp_valid, rsp_refetch, rsp_fixup, rsp_exc});
    end
    @(negedge clk); rst_n = 1;
    idle("R11");
    ck("R5 miss", 0, 3);
    ck("R6 miss", 1, 3);
    idle("R11 pulse");
    ins("R1", 5, 32'h100);
    ck("R1 clean", 0, 5);
    ck("R1 clean adv", 1, 5);
    ins("R4", 6, 32'h200);
    st("R4 same dw", 32'h107);
    st("R4 other dw", 32'h208 + 32'h10);
    ck("R4 conflicted", 1, 5);
    ck("R6 no change", 1, 5);
    ck("R4 untouched", 1, 6);
    ck("R5 refetch", 0, 5);
    ck("R5 cleared", 0, 5);
    ins("R7", 9, 32'h300, 1);
    ck("R7 ld", 0, 9);
    ck("R7 adv", 1, 9);
    ins("R2", 5, 32'h400);
    st("R2 old addr", 32'h100);
    ck("R2 replaced", 1, 5);
    ins("R2 defer swap", 9, 32'h300, 0);
    ck("R2 defer cleared", 0, 9);
    step("R8", 0, 1, 11, 32'h500, 0, 1, 32'h506, 0, 0, 0);
    ck("R8 conflicted", 1, 11);
    step("R10 store wins", 0, 0, 0, 0, 0, 1, 32'h400, 1, 0, 5);
    ck("R10 still conflicted", 0, 5);
    step("R10 pre-state", 0, 1, 12, 32'h600, 0, 0, 0, 1, 0, 12);
    ck("R10 now present", 0, 12);
    for (int i = 20; i < 28; i++) ins("R3 fill", i, 32'h1000 + 32'(i * 8));
    ck("R3 evicted", 1, 5);
    ck("R3 kept", 1, 20);
    ins("R3 ninth", 40, 32'h2000);
    ck("R3 oldest out", 0, 20);
    ck("R3 next kept", 0, 21);
    step("R9 flush+ins", 1, 1, 30, 32'h700, 0, 0, 0, 0, 0, 0);
    ck("R9 flushed", 0, 30);
    ck("R9 flushed adv", 1, 21);
    for (int n = 0; n < 3000; n++) begin
      step("R1-mix", ($urandom % 64) == 0, ($urandom % 3) == 0, $urandom % 12,
           32'($urandom % 16) << 2, ($urandom % 5) == 0, ($urandom % 3) == 0,
           32'($urandom % 16) << 2, ($urandom % 2) == 0, $urandom % 2, $urandom % 12);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end
endmodule